// File: doc/BRIEF.md
# Dual-Parity Stripe Syndrome Engine

This block computes two check words for one stripe offset of a dual-parity disk array. Data words for that offset arrive one at a time. The first word comes from the highest-numbered data disk and the last from disk 0. The engine keeps a running plain-XOR parity (P). It also keeps a running Reed-Solomon syndrome (Q) over GF(2^8), reduced by x^8+x^4+x^3+x^2+1. Each word is LANES bytes wide, and every byte lane is computed on its own, in parallel with the others.

Q is built by Horner's rule. The first word loads both accumulators. Each later word doubles Q in the field and then XORs the word in. P takes a plain XOR for each word. So after words d_(N-1) down to d_0, Q equals the sum of 2^i * d_i and P equals the XOR of all the d_i. When a word arrives flagged last, the engine registers P and Q onto its outputs and raises a valid pulse for one cycle. The first word of the next stripe may arrive in the very next cycle. In a full array the two results go to the two disks that follow the highest data disk.

Top module: `raid_pq_gen`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_p and out_q are all zeros until the first stripe completes.
- R2: An accepted word with in_first=1 discards any earlier accumulation and loads both P and Q with that word.
- R3: out_p equals the bytewise XOR of all words of the stripe.
- R4: out_q equals the result of Horner's rule: after loading the first (highest disk) word, each later word sets Q to double(Q) XOR word. This equals the XOR over disks i of 2^i * d_i in GF(2^8).
- R5: Doubling works per byte lane, where lane k is bits [8k+7:8k]. The lane byte shifts left by one with no carry into the next lane, and is XORed with 0x1D when its original bit 7 was 1.
- R6: out_valid is 1 for exactly the one cycle after the clock edge that accepts a word with in_valid=1 and in_last=1, and out_p/out_q carry that stripe's result in that cycle.
- R7: In all other cycles out_valid is 0, and out_p/out_q keep the last completed stripe's result.
- R8: Cycles with in_valid=0 are ignored: in_data, in_first and in_last have no effect on the accumulation or on the outputs.
- R9: The first word of a new stripe may be accepted in the cycle right after a last word, with no gap, and both stripes give correct results.
- R10: A stripe of one data disk (in_first and in_last on the same word) gives out_p = out_q = that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_data carries a data word this cycle |
| in_first | input | 1 | Word is from the highest data disk (starts a stripe) |
| in_last | input | 1 | Word is from disk 0 (ends a stripe) |
| in_data | input | LANES*8 | Data word, byte lane k in bits [8k+7:8k] |
| out_valid | output | 1 | One-cycle pulse: out_p/out_q hold a new result |
| out_p | output | LANES*8 | XOR parity of the last completed stripe |
| out_q | output | LANES*8 | GF(2^8) syndrome of the last completed stripe |

## Verification
The bench builds the engine with its default of 16 byte lanes, so each word carries 16 independent field computations at once. A lane that carries into its neighbour would show up against the per-lane reference. Random stripes run from 1 to 24 disks. That is far more than eight doublings, so the reduction by 0x1D is applied many times in a row, and high-order powers of 2 come into the expected Q. Random idle gaps with junk flags, stripes sent back to back, and directed single-disk and top-bit-set stripes cover the boundaries.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GF_RED = 8'h1D;

  // Multiply one field element by 2 (generator x) in GF(2^8).
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    gf_dbl = {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? GF_RED : '0);
  endfunction
endpackage

// File: rtl/rpq_lane.sv
module rpq_lane
  import rpq_pkg::*;
(
  input  logic [BYTE_W-1:0] d_i,
  input  logic [BYTE_W-1:0] p_i,
  input  logic [BYTE_W-1:0] q_i,
  input  logic              first_i,
  output logic [BYTE_W-1:0] p_o,
  output logic [BYTE_W-1:0] q_o
);
  always_comb begin
    if (first_i) begin
      p_o = d_i;
      q_o = d_i;
    end else begin
      p_o = p_i ^ d_i;
      q_o = gf_dbl(q_i) ^ d_i;
    end
  end
endmodule

// File: rtl/rpq_accum.sv
module rpq_accum
  import rpq_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_i,
  input  logic                      first_i,
  input  logic [LANES*BYTE_W-1:0]   data_i,
  output logic [LANES*BYTE_W-1:0]   p_nxt_o,
  output logic [LANES*BYTE_W-1:0]   q_nxt_o
);
  localparam int W = LANES * BYTE_W;

  logic [W-1:0] p_q, q_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rpq_lane u_lane (
      .d_i     (data_i[k*BYTE_W +: BYTE_W]),
      .p_i     (p_q[k*BYTE_W +: BYTE_W]),
      .q_i     (q_q[k*BYTE_W +: BYTE_W]),
      .first_i (first_i),
      .p_o     (p_nxt_o[k*BYTE_W +: BYTE_W]),
      .q_o     (q_nxt_o[k*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
    end else if (valid_i) begin
      p_q <= p_nxt_o;
      q_q <= q_nxt_o;
    end
  end

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && first_i |=> (p_q == $past(data_i)) && (q_q == $past(data_i))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(p_q) && $stable(q_q)); // R8
endmodule

// File: rtl/rpq_out.sv
module rpq_out #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] q_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_p_o,
  output logic [W-1:0] out_q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_p_o     <= '0;
      out_q_o     <= '0;
    end else begin
      out_valid_o <= done_i;
      if (done_i) begin
        out_p_o <= p_i;
        out_q_o <= q_i;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> out_valid_o); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !out_valid_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(out_p_o) && $stable(out_q_o)); // R7
endmodule

// File: rtl/raid_pq_gen.sv
module raid_pq_gen #(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic               in_last,
  input  logic [LANES*8-1:0] in_data,
  output logic               out_valid,
  output logic [LANES*8-1:0] out_p,
  output logic [LANES*8-1:0] out_q
);
  localparam int W = LANES * rpq_pkg::BYTE_W;

  logic [W-1:0] p_nxt, q_nxt;
  logic         stripe_done;

  assign stripe_done = in_valid & in_last;

  rpq_accum #(.LANES(LANES)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .first_i (in_first),
    .data_i  (in_data),
    .p_nxt_o (p_nxt),
    .q_nxt_o (q_nxt)
  );

  rpq_out #(.W(W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (stripe_done),
    .p_i         (p_nxt),
    .q_i         (q_nxt),
    .out_valid_o (out_valid),
    .out_p_o     (out_p),
    .out_q_o     (out_q)
  );

  AST_SINGLE_DISK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_first && in_last |=> (out_p == $past(in_data)) && (out_q == out_p)); // R10
  AST_GAPLESS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_done ##1 (in_valid && in_first && in_last) |=> out_valid && (out_p == $past(in_data))); // R9
endmodule

// File: tb/raid_pq_gen_tb.sv
module raid_pq_gen_tb_top;
  localparam int LANES = 16;
  localparam int W     = LANES * 8;
  localparam int MAXD  = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_first, in_last;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic [W-1:0] out_p, out_q;

  always #4 clk = ~clk;

  raid_pq_gen #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
    .out_p(out_p), .out_q(out_q)
  );

  int           n_cmp = 0;
  int           n_bad = 0;
  bit           armed = 0;
  bit           finished = 0;
  string        tag = "R3/R4";
  logic [W-1:0] exp_p, exp_q;
  logic [W-1:0] held_p = '0, held_q = '0;
  logic [W-1:0] stripe [MAXD];

  // Full carry-less product reduced by x^8+x^4+x^3+x^2+1.
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (acc[i]) acc ^= 16'h011D << (i - 8);
    return acc[7:0];
  endfunction

  function automatic logic [7:0] gpow2(input int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = gmul(r, 8'h02);
    return r;
  endfunction

  function automatic logic [W-1:0] ref_p(input int nd);
    logic [W-1:0] r = '0;
    for (int i = 0; i < nd; i++) r ^= stripe[i];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_q(input int nd);
    logic [W-1:0] r = '0;
    for (int i = 0; i < nd; i++)
      for (int k = 0; k < LANES; k++)
        r[k*8 +: 8] ^= gmul(gpow2(i), stripe[i][k*8 +: 8]);
    return r;
  endfunction

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] r;
    for (int k = 0; k < W / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Output checker, 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (armed) begin
        chk(out_valid === 1'b1, "R6 valid pulse", W'(out_valid), W'(1));
        chk(out_p === exp_p, {tag, " P (R3)"}, out_p, exp_p);
        chk(out_q === exp_q, {tag, " Q (R4)"}, out_q, exp_q);
        held_p = exp_p;
        held_q = exp_q;
        armed  = 0;
      end else begin
        chk(out_valid === 1'b0, "R7 no pulse", W'(out_valid), W'(0));
        chk(out_p === held_p && out_q === held_q, "R7/R8 hold", out_p ^ out_q,
            held_p ^ held_q);
      end
    end
  end

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'($urandom);
    in_last  = 1'($urandom);
    in_data  = rand_word();
  endtask

  // Sends stripe[nd-1] down to stripe[0]; leaves in_valid high after the last word.
  task automatic send_stripe(input int nd, input int gap_pct, input string t);
    for (int i = nd - 1; i >= 0; i--) begin
      if (i != nd - 1)
        while (int'($urandom % 100) < gap_pct) idle_cycle();
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == nd - 1);
      in_last  = (i == 0);
      in_data  = stripe[i];
      if (i == 0) begin
        exp_p = ref_p(nd);
        exp_q = ref_q(nd);
        tag   = t;
        armed = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_p === '0 && out_q === '0, "R1 reset state",
        out_p | out_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) idle_cycle();
    chk(out_valid === 1'b0 && out_p === '0 && out_q === '0, "R1 after release",
        out_p | out_q, '0);

    // R10: one data disk.
    stripe[0] = rand_word();
    send_stripe(1, 0, "R10 single disk");
    idle_cycle();

    // R5: top bit set in every lane, next word zero -> Q lanes are 0x1D.
    stripe[1] = {LANES{8'h80}};
    stripe[0] = '0;
    send_stripe(2, 0, "R5 reduce");
    idle_cycle();
    chk(out_q === {LANES{8'h1D}}, "R5 literal 0x1D", out_q, {LANES{8'h1D}});

    // R5: alternating 0xFF / 0x01 lanes, no carry between lanes.
    for (int k = 0; k < LANES; k++) stripe[2][k*8 +: 8] = k[0] ? 8'h01 : 8'hFF;
    stripe[1] = '0;
    stripe[0] = rand_word();
    send_stripe(3, 0, "R5 lane isolation");
    idle_cycle();

    // R9/R10: back-to-back single-disk stripes, then a gapless multi-disk one.
    for (int n = 0; n < 3; n++) begin
      stripe[0] = rand_word();
      send_stripe(1, 0, "R9 R10 back-to-back");
    end
    for (int i = 0; i < 5; i++) stripe[i] = rand_word();
    send_stripe(5, 0, "R9 R2 gapless restart");

    // Random stripes, gaps with junk flags (R8), long Horner chains (R4).
    for (int n = 0; n < 300; n++) begin
      int nd = 1 + int'($urandom % MAXD);
      for (int i = 0; i < nd; i++) stripe[i] = rand_word();
      send_stripe(nd, (n % 3 == 0) ? 0 : 30, "R3 R4 R8 random");
      if ($urandom % 2) repeat (1 + $urandom % 3) idle_cycle();
    end
    repeat (3) idle_cycle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule